// File: doc/BRIEF.md
# Sliding-Window Event Rate Checker

This block watches a single-bit event line and confirms that the event occurs an exact number of times inside a fixed span of clock cycles. In its default sliding form it keeps the most recent `WIN` samples, holds a running tally of how many of them were high, and raises a violation on every cycle whose window holds more or fewer events than `TARGET`. It stays quiet until a full window has been collected since reset, so a partly filled history never produces a false alarm.

A second form, picked by the `MODE` parameter, does not slide. Here an event that arrives while no window is open anchors a new window. The anchor and the events in the next `WIN-1` cycles are added up, and a verdict is given once the window closes. Events that arrive while a window is open are counted but do not start another window.

Both forms drive the same outputs. These are a one-cycle violation flag, a ready flag that marks a cycle carrying a verdict, the current tally, and a sticky error bit that only reset clears. The block is a passive monitor. It has no effect on the event line it watches.

Top module: `rate_window_checker`

## Requirements
- R1: In sliding mode, one cycle after a rising edge that samples `event_i`, `count_o` equals the number of ones among the last min(k, WIN) samples taken since reset, where k is the number of samples. A sample is the value `event_i` held just before the edge.
- R2: In sliding mode, `ready_o` is 0 after fewer than WIN samples since reset. From the WIN-th sample on it is 1 and it stays 1 until reset.
- R3: `violation_o` is 1 in exactly the cycles where `ready_o` is 1 and `count_o` differs from TARGET. This covers too many events as well as too few. In sliding mode a window with exactly TARGET events gives no violation.
- R4: `error_o` becomes 1 in the same cycle as the first `violation_o` pulse. It then stays 1 until reset.
- R5: While `rst_n` is low at a rising edge, the history, tally, fill progress, any open window and all outputs are cleared to 0 at that edge.
- R6: In anchored mode, an event sampled while no window is open opens a window of WIN samples, counting the anchor as the first. During the window `count_o` shows the running total. In the cycle after the last sample, `ready_o` is 1 for that one cycle and `count_o` holds the window total. `violation_o` is 1 in that cycle if the total differs from TARGET.
- R7: In anchored mode, an event sampled while a window is open does not open a new window or restart the open one. An event sampled in the cycle after a window's last sample opens a new window.
- R8: `count_o` is $clog2(WIN+1) bits wide and never exceeds WIN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| event_i | input | 1 | Event line being watched |
| violation_o | output | 1 | High for the cycle whose verdict mismatches TARGET |
| ready_o | output | 1 | Sliding: window full; anchored: verdict cycle |
| count_o | output | $clog2(WIN+1) | Current event tally |
| error_o | output | 1 | Sticky violation flag, cleared only by reset |

## Verification
The bench builds two copies with WIN = 8 and TARGET = 3, one sliding and one anchored. Both copies are fed the same event stream. The short window lets a few dozen cycles cover the partial-fill phase, windows that slide past the ready point, bursts that overshoot the target, sparse runs that fall short, and periodic patterns that hit it exactly. With a small target, an anchored window that opens in the middle of a burst sees other events land inside it. That shows the no-restart rule and the re-anchoring right after a window closes.

// File: rtl/rwc_pkg.sv
// Shared definitions for the rate window checker.
// Assumes nothing beyond IEEE 1800-2017 packages.
package rwc_pkg;
    // Window style selected at elaboration
    typedef enum logic {
        WIN_SLIDE  = 1'b0,
        WIN_ANCHOR = 1'b1
    } win_mode_e;
endpackage

// File: rtl/rwc_slide_hist.sv
// Sliding history engine: shifts every sample into a WIN-deep register,
// keeps a running tally (add incoming, drop outgoing) and a saturating
// fill counter. It exports both the next-state values (for an aligned
// verdict) and the registered values.
// Assumes WIN >= 2 and CW = $clog2(WIN+1).
module rwc_slide_hist #(
    parameter int WIN = 100,
    parameter int CW  = $clog2(WIN + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ev,
    output logic [CW-1:0] cnt_d,
    output logic          rdy_d,
    output logic [CW-1:0] cnt_q,
    output logic          rdy_q
);
    localparam logic [CW-1:0] FULL = CW'(WIN);

    logic [WIN-1:0] hist_q;
    logic [CW-1:0]  fill_q;
    logic [CW-1:0]  fill_d;
    logic           leaving;

    // Next tally and fill progress for the sample arriving at this edge
    always_comb begin
        leaving = hist_q[WIN-1];
        cnt_d   = cnt_q + CW'(ev) - CW'(leaving);
        fill_d  = (fill_q == FULL) ? fill_q : fill_q + CW'(1);
        rdy_d   = (fill_d == FULL);
    end

    // History, tally, fill and ready registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist_q <= '0;
            cnt_q  <= '0;
            fill_q <= '0;
            rdy_q  <= 1'b0;
        end else begin
            hist_q <= {hist_q[WIN-2:0], ev};
            cnt_q  <= cnt_d;
            fill_q <= fill_d;
            rdy_q  <= rdy_d;
        end
    end

    // R1: one sample enters and at most one leaves, so the tally moves by at most one
    a_r1_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((cnt_q <= $past(cnt_q) + CW'(1)) && (cnt_q + CW'(1) >= $past(cnt_q))));

    // R8: the tally can never exceed the window depth
    a_r8_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= FULL);

    // R2: once the window is full it stays full until reset
    a_r2_ready_holds: assert property (@(posedge clk) disable iff (!rst_n)
        rdy_q |=> rdy_q);
endmodule

// File: rtl/rwc_anchor_win.sv
// Anchored window engine: an event seen while idle opens a window of WIN
// samples (the anchor being the first). Events inside an open window are
// counted but never re-anchor. On the last sample a one-cycle done flag
// is raised and the total is held until the next window opens.
// Assumes WIN >= 1 and CW = $clog2(WIN+1).
module rwc_anchor_win #(
    parameter int WIN = 100,
    parameter int CW  = $clog2(WIN + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ev,
    output logic [CW-1:0] cnt_d,
    output logic          rdy_d,
    output logic [CW-1:0] cnt_q,
    output logic          rdy_q
);
    localparam logic [CW-1:0] LAST = CW'(WIN);

    logic          open_q, open_d;
    logic [CW-1:0] pos_q, pos_d;
    logic          start, busy;

    // Decide whether this sample opens, extends or closes a window
    always_comb begin
        start = !open_q && ev;
        busy  = start || open_q;
        if (start) begin
            cnt_d = CW'(1);
            pos_d = CW'(1);
        end else if (open_q) begin
            cnt_d = cnt_q + CW'(ev);
            pos_d = pos_q + CW'(1);
        end else begin
            cnt_d = cnt_q;
            pos_d = pos_q;
        end
        rdy_d  = busy && (pos_d == LAST);
        open_d = busy && !rdy_d;
    end

    // Window state registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open_q <= 1'b0;
            pos_q  <= '0;
            cnt_q  <= '0;
            rdy_q  <= 1'b0;
        end else begin
            open_q <= open_d;
            pos_q  <= pos_d;
            cnt_q  <= cnt_d;
            rdy_q  <= rdy_d;
        end
    end

    // R7: an open window never runs past its last sample
    a_r7_pos_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        open_q |-> (pos_q < LAST));

    // R8: the window total never exceeds the samples taken in it
    a_r8_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (open_q || rdy_q) |-> (cnt_q <= pos_q));

    // R6: with a window longer than one sample, a verdict cycle is never repeated back to back
    if (WIN > 1) begin : g_single_done
        a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
            rdy_q |=> !rdy_q);
    end
endmodule

// File: rtl/rwc_verdict.sv
// Verdict stage: registers the mismatch pulse from the engine's next-state
// tally and ready, so the pulse lines up with the registered tally, and
// keeps a sticky error bit.
// Assumes the engine's registered ready follows rdy_d by one edge.
module rwc_verdict #(
    parameter int TARGET = 5,
    parameter int CW     = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] cnt_d,
    input  logic          rdy_d,
    input  logic          rdy_q,
    output logic          viol_q,
    output logic          err_q
);
    localparam logic [CW-1:0] GOAL = CW'(TARGET);

    logic miss;

    // Exact comparison; too many and too few both miss
    always_comb miss = rdy_d && (cnt_d != GOAL);

    // Pulse and sticky error registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            viol_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            viol_q <= miss;
            err_q  <= err_q | miss;
        end
    end

    // R3: a violation is only reported on a cycle that carries a verdict
    a_r3_viol_needs_ready: assert property (@(posedge clk) disable iff (!rst_n)
        viol_q |-> rdy_q);

    // R4: the sticky bit is set with every violation
    a_r4_err_follows_viol: assert property (@(posedge clk) disable iff (!rst_n)
        viol_q |-> err_q);

    // R4: once set, the sticky bit holds until reset
    a_r4_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |=> err_q);
endmodule

// File: rtl/rate_window_checker.sv
// Top of the event rate checker. Picks the sliding or the anchored engine
// by MODE and feeds its tally to the verdict stage.
// Assumes a synchronous active-low reset; event_i is sampled at the rising edge.
module rate_window_checker
    import rwc_pkg::*;
#(
    parameter int        WIN    = 100,
    parameter int        TARGET = 5,
    parameter win_mode_e MODE   = WIN_SLIDE,
    localparam int       CW     = $clog2(WIN + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          event_i,
    output logic          violation_o,
    output logic          ready_o,
    output logic [CW-1:0] count_o,
    output logic          error_o
);
    logic [CW-1:0] cnt_d, cnt_q;
    logic          rdy_d, rdy_q;

    if (MODE == WIN_SLIDE) begin : g_slide
        rwc_slide_hist #(.WIN(WIN), .CW(CW)) u_engine (
            .clk   (clk),
            .rst_n (rst_n),
            .ev    (event_i),
            .cnt_d (cnt_d),
            .rdy_d (rdy_d),
            .cnt_q (cnt_q),
            .rdy_q (rdy_q)
        );
    end else begin : g_anchor
        rwc_anchor_win #(.WIN(WIN), .CW(CW)) u_engine (
            .clk   (clk),
            .rst_n (rst_n),
            .ev    (event_i),
            .cnt_d (cnt_d),
            .rdy_d (rdy_d),
            .cnt_q (cnt_q),
            .rdy_q (rdy_q)
        );
    end

    rwc_verdict #(.TARGET(TARGET), .CW(CW)) u_verdict (
        .clk    (clk),
        .rst_n  (rst_n),
        .cnt_d  (cnt_d),
        .rdy_d  (rdy_d),
        .rdy_q  (rdy_q),
        .viol_q (violation_o),
        .err_q  (error_o)
    );

    assign count_o = cnt_q;
    assign ready_o = rdy_q;
endmodule

// File: tb/rate_window_checker_bench.sv
// Bench: one sliding and one anchored copy (WIN=8, TARGET=3) share a stream.
module rate_window_checker_bench;
    import rwc_pkg::*;

    localparam int WIN = 8;
    localparam int TGT = 3;
    localparam int CW  = $clog2(WIN + 1);
    localparam int NSTIM = 48;
    // Stimulus table, bit NSTIM-1 applied first
    localparam logic [NSTIM-1:0] STIM =
        48'b10010010_11100000_11100000_11111111_00000001_01101100;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ev = 1'b0;
    logic          s_viol, s_rdy, s_err, a_viol, a_rdy, a_err;
    logic [CW-1:0] s_cnt, a_cnt;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Reference state
    logic [WIN-1:0] m_hist;
    int m_fill;
    bit m_serr;
    bit m_open, m_done, m_aerr;
    int m_pos, m_tot;

    always #2 clk = ~clk;

    rate_window_checker #(.WIN(WIN), .TARGET(TGT), .MODE(WIN_SLIDE)) u_rate_window_checker (
        .clk(clk), .rst_n(rst_n), .event_i(ev),
        .violation_o(s_viol), .ready_o(s_rdy), .count_o(s_cnt), .error_o(s_err));

    rate_window_checker #(.WIN(WIN), .TARGET(TGT), .MODE(WIN_ANCHOR)) u_rate_window_checker_anchor (
        .clk(clk), .rst_n(rst_n), .event_i(ev),
        .violation_o(a_viol), .ready_o(a_rdy), .count_o(a_cnt), .error_o(a_err));

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic model_reset();
        m_hist = '0; m_fill = 0; m_serr = 0;
        m_open = 0; m_done = 0; m_aerr = 0; m_pos = 0; m_tot = 0;
    endtask

    task automatic model_advance(input logic e);
        bit start, was_open;
        m_hist = {m_hist[WIN-2:0], e};
        if (m_fill < WIN) m_fill++;
        if (m_fill == WIN && $countones(m_hist) != TGT) m_serr = 1;
        was_open = m_open;
        start = !m_open && e;
        m_done = 0;
        if (start) begin m_tot = 1; m_pos = 1; m_open = 1; end
        else if (was_open) begin m_tot += int'(e); m_pos++; end
        if ((start || was_open) && m_pos == WIN) begin m_open = 0; m_done = 1; end
        if (m_done && m_tot != TGT) m_aerr = 1;
    endtask

    task automatic compare();
        int sc;
        bit sr;
        sc = $countones(m_hist);
        sr = (m_fill == WIN);
        chk("R1", "slide count", int'(s_cnt), sc);
        chk("R2", "slide ready", int'(s_rdy), int'(sr));
        chk("R3", "slide violation", int'(s_viol), int'(sr && sc != TGT));
        chk("R4", "slide error", int'(s_err), int'(m_serr));
        chk("R6", "anchor count", int'(a_cnt), m_tot);
        chk("R6", "anchor ready", int'(a_rdy), int'(m_done));
        chk("R6", "anchor violation", int'(a_viol), int'(m_done && m_tot != TGT));
        chk("R4", "anchor error", int'(a_err), int'(m_aerr));
    endtask

    // Apply one sample, let one edge pass, then check off the edge
    task automatic step(input logic e);
        ev = e;
        @(posedge clk);
        #1;
        if (!rst_n) model_reset(); else model_advance(e);
        compare();
    endtask

    task automatic reset_pulse();
        rst_n = 1'b0;
        step(1'b1);
        step(1'b1);
        chk("R5", "slide outputs cleared", int'({s_viol, s_rdy, s_err}) + int'(s_cnt), 0);
        chk("R5", "anchor outputs cleared", int'({a_viol, a_rdy, a_err}) + int'(a_cnt), 0);
        rst_n = 1'b1;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : main
        model_reset();
        reset_pulse();
        chk("R8", "count width", $bits(s_cnt), CW);

        // R2: ready rises exactly on the WIN-th sample
        for (int i = 0; i < WIN - 1; i++) step(1'b0);
        chk("R2", "not ready before WIN samples", int'(s_rdy), 0);
        step(1'b0);
        chk("R2", "ready at WIN samples", int'(s_rdy), 1);
        chk("R3", "too few events flagged", int'(s_viol), 1);

        // Table walk
        reset_pulse();
        for (int i = NSTIM - 1; i >= 0; i--) step(STIM[i]);

        // R3: exactly TARGET in every window clears the pulse
        reset_pulse();
        for (int r = 0; r < 3; r++)
            for (int i = 0; i < WIN; i++) step(i < TGT);
        chk("R3", "exact count no violation", int'(s_viol), 0);
        chk("R4", "no error on exact stream", int'(s_err), 0);

        // R3: overshoot flagged
        for (int i = 0; i < WIN; i++) step(1'b1);
        chk("R3", "too many events flagged", int'(s_viol), 1);
        chk("R8", "count saturates at WIN", int'(s_cnt), WIN);

        // R7: events inside an open window never re-anchor
        reset_pulse();
        step(1'b1);
        for (int i = 1; i < WIN; i++) begin
            step(i % 2 == 1);
            if (i < WIN - 1) chk("R7", "no verdict mid window", int'(a_rdy), 0);
        end
        chk("R7", "verdict on anchor plus WIN-1", int'(a_rdy), 1);
        chk("R7", "window total", int'(a_cnt), 1 + (WIN - 1 + 1) / 2);
        step(1'b1);
        chk("R7", "re-anchor after close", int'(a_cnt), 1);
        chk("R7", "new window not yet done", int'(a_rdy), 0);

        // R5: reset mid-run clears sticky state
        reset_pulse();
        step(1'b0);
        chk("R5", "error cleared after reset", int'(s_err) + int'(a_err), 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule